// File: doc/BRIEF.md
# Paired NOR Flash Command Sequencer

This block sits between a requester and a 32-bit memory bus that carries two 16-bit NOR flash devices side by side. The low 16 bits go to one device and the high 16 bits to the other. Each request is either a sector erase or a single 32-bit word program. The block issues the command writes, then polls the status of each device on its own. When both devices have reached a final state, it writes the return-to-read command, reads the word back after a program, and reports one combined result.

A program request starts with a read of the target word. Only bits that are still set in the flash can be programmed, so the request is refused when the new data needs a bit that is already cleared. Waiting is bounded by a counter of external tick pulses. The counter is cleared when the last command write of a sequence goes out, and its limit comes from an input port. The result is a 2-bit code with a one-cycle done pulse.

The state machine has these states. IDLE waits for a request. PRE_RD and PRE_EV read and check the target word before a program. CMD issues one command write per cycle. POLL_RD, POLL_EV and POLL_DEC form the polling loop. RR_RD and RR_EV re-read the word for a device that flagged a fault. RST_WR writes the return-to-read command. VFY_RD and VFY_EV read the programmed word back. DONE gives the result pulse.

The transitions are as follows:
- IDLE goes to CMD for an erase and to PRE_RD for a program.
- PRE_EV goes to DONE when the word is not erased, otherwise to CMD.
- CMD goes to POLL_RD after its last write.
- POLL_DEC goes to RST_WR when both halves are final or the timer has expired, to RR_RD when a half is waiting for a re-read, and otherwise to POLL_RD.
- RR_EV goes to POLL_DEC.
- RST_WR goes to VFY_RD after a program that did not time out, otherwise to DONE.
- VFY_EV goes to DONE, and DONE goes to IDLE.

Top module: `pnor_seq`

## Requirements
- R1: Out of reset and whenever idle, req_ready is 1, done is 0, and neither bus_we nor bus_re is asserted.
- R2: Every command write carries its 8-bit code in bits 7:0 and again in bits 23:16, with zeros elsewhere. The first unlock write is code AA at byte address 0x1554 (word offset 0x555 shifted left by 2). The second is code 55 at byte address 0xAA8 (offset 0x2AA).
- R3: An erase (req_op=0) issues six writes, one per cycle: AA@0x1554, 55@0xAA8, 80@0x1554, AA@0x1554, 55@0xAA8, then 30 at req_addr.
- R4: A program (req_op=1) first reads req_addr. It then issues five writes: AA@0x1554, 55@0xAA8, 20@0x1554, A0@req_addr, then req_data itself at req_addr.
- R5: If the pre-read word AND req_data differs from req_data, the request ends with status 3 (not erased) and no bus write is made.
- R6: During an erase, each half is sampled at req_addr. Bit 7 of a half set makes that half done. Otherwise bit 5 set makes it failed. Any failed half gives status 1; two done halves give status 0.
- R7: During a program, a half is done when its bit 7 equals bit 7 of that half of req_data. If bit 7 differs and bit 5 is set, the word is read once more: a matching bit 7 then makes the half done, otherwise failed (status 1).
- R8: Polling repeats until both halves are final. If at a decision point they are not both final and the timer has expired, the result is status 2 (timeout). Either way the next write is code F0.
- R9: After an erase, F0 is written at 0x1554. After a program, F0 is written at req_addr, then req_addr is read back, and a value other than req_data gives status 1.
- R10: done is a one-cycle pulse, with status valid in that cycle, and the block is idle in the next cycle. A request presented while the block is busy is ignored.
- R11: The timer is cleared in the cycle of the last command write. From the next cycle it counts tick pulses, and it has expired when its count is at least tmo_limit (a limit of 0 has expired at once).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 1 | 0 = sector erase, 1 = word program |
| req_addr | input | AW | Sector or word byte address |
| req_data | input | 32 | Word to program |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_we | output | 1 | Write strobe, one write per cycle |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | 32 | Read data, valid the cycle after bus_re |
| tick | input | 1 | Timeout time base pulse |
| tmo_limit | input | TW | Timeout limit in ticks |
| done | output | 1 | Result pulse |
| status | output | 2 | 0 ok, 1 program error, 2 timeout, 3 not erased |

## Verification
The bench uses the default AW=24 and TW=16 and drives tick high in every cycle, so the timer counts cycles from the last command write. With small tmo_limit values, the exact boundary between a late completion and a timeout can be reached. A two-busy-read case passes at a limit of 6 and times out at 5, and a limit of 0 still lets an immediate completion through. The flash model can keep each half busy for a chosen number of reads, fail it, or raise the fault bit once before recovering. This exercises the independent per-half states and the re-read path.

// File: rtl/pnor_pkg.sv
package pnor_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_PRE_RD, S_PRE_EV, S_CMD,
        S_POLL_RD, S_POLL_EV, S_POLL_DEC,
        S_RR_RD, S_RR_EV, S_RST_WR,
        S_VFY_RD, S_VFY_EV, S_DONE
    } pnor_state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_PERR    = 2'd1,
        RES_TMO     = 2'd2,
        RES_NERASED = 2'd3
    } pnor_res_e;

    localparam logic [10:0] UNLOCK1_OFS = 11'h555;
    localparam logic [10:0] UNLOCK2_OFS = 11'h2AA;

    localparam logic [7:0] CODE_UNL1  = 8'hAA;
    localparam logic [7:0] CODE_UNL2  = 8'h55;
    localparam logic [7:0] CODE_ESET  = 8'h80;
    localparam logic [7:0] CODE_ECONF = 8'h30;
    localparam logic [7:0] CODE_BYP   = 8'h20;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_RDARR = 8'hF0;

    function automatic logic [31:0] dup_code(input logic [7:0] code);
        return {8'h00, code, 8'h00, code};
    endfunction

endpackage

// File: rtl/pnor_cmd_gen.sv
module pnor_cmd_gen #(
    parameter int AW = 24,
    parameter int SW = 3
) (
    input  logic          is_prog,
    input  logic [SW-1:0] step,
    input  logic [AW-1:0] tgt,
    input  logic [31:0]   data,
    output logic [AW-1:0] addr,
    output logic [31:0]   wdata,
    output logic          last
);
    import pnor_pkg::*;

    localparam logic [AW-1:0] U1 = AW'({UNLOCK1_OFS, 2'b00});
    localparam logic [AW-1:0] U2 = AW'({UNLOCK2_OFS, 2'b00});

    always_comb begin
        addr  = U1;
        wdata = dup_code(CODE_UNL1);
        last  = 1'b0;
        if (!is_prog) begin
            unique case (step)
                SW'(0): begin addr = U1;  wdata = dup_code(CODE_UNL1);  end
                SW'(1): begin addr = U2;  wdata = dup_code(CODE_UNL2);  end
                SW'(2): begin addr = U1;  wdata = dup_code(CODE_ESET);  end
                SW'(3): begin addr = U1;  wdata = dup_code(CODE_UNL1);  end
                SW'(4): begin addr = U2;  wdata = dup_code(CODE_UNL2);  end
                SW'(5): begin addr = tgt; wdata = dup_code(CODE_ECONF); last = 1'b1; end
                default: begin addr = tgt; wdata = dup_code(CODE_ECONF); last = 1'b1; end
            endcase
        end else begin
            unique case (step)
                SW'(0): begin addr = U1;  wdata = dup_code(CODE_UNL1); end
                SW'(1): begin addr = U2;  wdata = dup_code(CODE_UNL2); end
                SW'(2): begin addr = U1;  wdata = dup_code(CODE_BYP);  end
                SW'(3): begin addr = tgt; wdata = dup_code(CODE_PROG); end
                SW'(4): begin addr = tgt; wdata = data; last = 1'b1; end
                default: begin addr = tgt; wdata = data; last = 1'b1; end
            endcase
        end
    end

endmodule

// File: rtl/pnor_half_poll.sv
module pnor_half_poll (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sample,
    input  logic reread,
    input  logic is_prog,
    input  logic rd7,
    input  logic rd5,
    input  logic want7,
    output logic fin,
    output logic err,
    output logic rr
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fin <= 1'b0;
            err <= 1'b0;
            rr  <= 1'b0;
        end else if (reread && rr) begin
            rr  <= 1'b0;
            fin <= 1'b1;
            err <= (rd7 != want7);
        end else if (sample && !fin && !rr) begin
            if (is_prog) begin
                if (rd7 == want7) begin
                    fin <= 1'b1;
                end else if (rd5) begin
                    rr <= 1'b1;
                end
            end else begin
                if (rd7) begin
                    fin <= 1'b1;
                end else if (rd5) begin
                    fin <= 1'b1;
                    err <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pnor_tmo.sv
module pnor_tmo #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam logic [TW-1:0] CMAX = {TW{1'b1}};

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick && cnt != CMAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= limit);

endmodule

// File: rtl/pnor_seq.sv
module pnor_seq #(
    parameter int AW = 24,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_data,
    output logic          req_ready,
    output logic [AW-1:0] bus_addr,
    output logic [31:0]   bus_wdata,
    output logic          bus_we,
    output logic          bus_re,
    input  logic [31:0]   bus_rdata,
    input  logic          tick,
    input  logic [TW-1:0] tmo_limit,
    output logic          done,
    output logic [1:0]    status
);
    import pnor_pkg::*;

    localparam int HALVES = 2;
    localparam int HW     = 32 / HALVES;
    localparam int SW     = 3;
    localparam logic [AW-1:0] U1 = AW'({UNLOCK1_OFS, 2'b00});

    pnor_state_e   state, state_d;
    pnor_res_e     res_q, res_d;
    logic [SW-1:0] step, step_d;
    logic          op_q;
    logic [AW-1:0] addr_q;
    logic [31:0]   data_q;

    logic          accept;
    logic [AW-1:0] cmd_addr;
    logic [31:0]   cmd_wdata;
    logic          cmd_last;
    logic          tmo_clr, expired;
    logic [HALVES-1:0] h_fin, h_err, h_rr;
    logic          h_sample, h_reread;
    logic          all_fin, any_err, any_rr;

    assign accept = (state == S_IDLE) && req_valid;

    pnor_cmd_gen #(.AW(AW), .SW(SW)) u_cmd (
        .is_prog (op_q),
        .step    (step),
        .tgt     (addr_q),
        .data    (data_q),
        .addr    (cmd_addr),
        .wdata   (cmd_wdata),
        .last    (cmd_last)
    );

    assign tmo_clr = (state == S_CMD) && cmd_last;

    pnor_tmo #(.TW(TW)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmo_clr),
        .tick    (tick),
        .limit   (tmo_limit),
        .expired (expired)
    );

    assign h_sample = (state == S_POLL_EV);
    assign h_reread = (state == S_RR_EV);

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        pnor_half_poll u_poll (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (accept),
            .sample  (h_sample),
            .reread  (h_reread),
            .is_prog (op_q),
            .rd7     (bus_rdata[h*HW + 7]),
            .rd5     (bus_rdata[h*HW + 5]),
            .want7   (data_q[h*HW + 7]),
            .fin     (h_fin[h]),
            .err     (h_err[h]),
            .rr      (h_rr[h])
        );
    end

    assign all_fin = &h_fin;
    assign any_err = |h_err;
    assign any_rr  = |h_rr;

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            res_q  <= RES_OK;
            step   <= '0;
            op_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            state <= state_d;
            res_q <= res_d;
            step  <= step_d;
            if (accept) begin
                op_q   <= req_op;
                addr_q <= req_addr;
                data_q <= req_data;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state;
        res_d   = res_q;
        step_d  = step;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    step_d  = '0;
                    res_d   = RES_OK;
                    state_d = req_op ? S_PRE_RD : S_CMD;
                end
            end
            S_PRE_RD: state_d = S_PRE_EV;
            S_PRE_EV: begin
                if ((bus_rdata & data_q) != data_q) begin
                    res_d   = RES_NERASED;
                    state_d = S_DONE;
                end else begin
                    state_d = S_CMD;
                end
            end
            S_CMD: begin
                step_d = step + 1'b1;
                if (cmd_last) state_d = S_POLL_RD;
            end
            S_POLL_RD: state_d = S_POLL_EV;
            S_POLL_EV: state_d = S_POLL_DEC;
            S_POLL_DEC: begin
                if (all_fin) begin
                    res_d   = any_err ? RES_PERR : RES_OK;
                    state_d = S_RST_WR;
                end else if (expired) begin
                    res_d   = RES_TMO;
                    state_d = S_RST_WR;
                end else if (any_rr) begin
                    state_d = S_RR_RD;
                end else begin
                    state_d = S_POLL_RD;
                end
            end
            S_RR_RD:  state_d = S_RR_EV;
            S_RR_EV:  state_d = S_POLL_DEC;
            S_RST_WR: state_d = (op_q && res_q != RES_TMO) ? S_VFY_RD : S_DONE;
            S_VFY_RD: state_d = S_VFY_EV;
            S_VFY_EV: begin
                if (bus_rdata != data_q) res_d = RES_PERR;
                state_d = S_DONE;
            end
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_addr  = addr_q;
        bus_wdata = '0;
        unique case (state)
            S_IDLE:   req_ready = 1'b1;
            S_PRE_RD, S_POLL_RD, S_RR_RD, S_VFY_RD: bus_re = 1'b1;
            S_CMD: begin
                bus_we    = 1'b1;
                bus_addr  = cmd_addr;
                bus_wdata = cmd_wdata;
            end
            S_RST_WR: begin
                bus_we    = 1'b1;
                bus_addr  = op_q ? addr_q : U1;
                bus_wdata = dup_code(CODE_RDARR);
            end
            S_DONE:   done = 1'b1;
            default: ;
        endcase
    end

    assign status = res_q;

endmodule

// File: rtl/pnor_seq_chk.sv
module pnor_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        bus_we,
    input logic        bus_re,
    input logic [31:0] bus_wdata,
    input logic        done,
    input logic [1:0]  status
);
    logic [7:0] wcnt;

    always_ff @(posedge clk) begin
        if (!rst_n || (req_valid && req_ready)) begin
            wcnt <= '0;
        end else if (bus_we && wcnt != 8'hFF) begin
            wcnt <= wcnt + 8'd1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_we && !bus_re));

    // R1
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    // R5
    nerased_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd3) |-> (wcnt == 8'd0));

    // R8
    tmo_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd2) |-> ($past(bus_we) && $past(bus_wdata) == 32'h00F000F0));

endmodule

bind pnor_seq pnor_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .done      (done),
    .status    (status)
);

// File: tb/sim_pnor_seq.sv
`timescale 1ns/1ps
module sim_pnor_seq;
    localparam int AW = 24;
    localparam int TW = 16;
    localparam int HANG = 1000000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_op = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_data = '0;
    logic          req_ready;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic          bus_we, bus_re;
    logic [31:0]   bus_rdata = '0;
    logic          tick = 1'b1;
    logic [TW-1:0] tmo_limit = 16'd1000;
    logic          done;
    logic [1:0]    status;

    always #4 clk = ~clk;

    pnor_seq #(.AW(AW), .TW(TW)) u0 (.*);

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural paired flash model ----------------
    logic [31:0] fmem [64];
    int          busy_cnt [2];
    int          hmode [2];      // 0 normal, 1 fail, 2 fault bit once then ok
    bit          rr_seen [2];
    logic [31:0] corrupt;
    bit          mbusy = 0, mprog = 0, last_a0 = 0, erase_armed = 0, prog_seen = 0;
    logic [31:0] mdata;
    logic [AW-1:0] wlog_a [16];
    logic [31:0]   wlog_d [16];
    int          wn = 0;

    always @(posedge clk) begin
        if (bus_we) begin
            if (wn < 16) begin wlog_a[wn] = bus_addr; wlog_d[wn] = bus_wdata; end
            wn++;
            if (last_a0) begin
                fmem[bus_addr[7:2]] = fmem[bus_addr[7:2]] & bus_wdata;
                mbusy = 1; mprog = 1; mdata = bus_wdata; last_a0 = 0; prog_seen = 1;
            end else begin
                last_a0 = (bus_wdata == 32'h00A000A0);
                if (bus_wdata == 32'h00F000F0) mbusy = 0;
                if (bus_wdata == 32'h00800080) erase_armed = 1;
                if (bus_wdata == 32'h00300030 && erase_armed) begin
                    erase_armed = 0; mbusy = 1; mprog = 0;
                    for (int i = 0; i < 64; i++) fmem[i] = 32'hFFFFFFFF;
                end
            end
        end
        if (bus_re) begin
            if (!mbusy) begin
                bus_rdata <= fmem[bus_addr[7:2]] ^ (prog_seen ? corrupt : 32'h0);
            end else begin
                logic [31:0] v;
                v = '0;
                for (int h = 0; h < 2; h++) begin
                    logic [15:0] hv;
                    logic d7;
                    d7 = mdata[16*h+7];
                    if (busy_cnt[h] > 0) begin
                        hv = mprog ? {8'h00, ~d7, 7'h00} : 16'h0000;
                        busy_cnt[h]--;
                    end else if (hmode[h] == 1 || (hmode[h] == 2 && mprog && !rr_seen[h])) begin
                        hv = mprog ? {8'h00, ~d7, 1'b0, 1'b1, 5'h00} : 16'h0020;
                        if (hmode[h] == 2) rr_seen[h] = 1;
                    end else begin
                        hv = mprog ? mdata[16*h +: 16] : 16'hFFFF;
                    end
                    v[16*h +: 16] = hv;
                end
                bus_rdata <= v;
            end
        end
    end

    // ---------------- expectations from the requirements ----------------
    function automatic void exp_w(input logic op, input int i, input logic [AW-1:0] ta,
                                  input logic [31:0] td, output logic [AW-1:0] a, output logic [31:0] d);
        logic [7:0] ec [6];
        logic [7:0] pc [4];
        ec = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
        pc = '{8'hAA, 8'h55, 8'h20, 8'hA0};
        a = 24'h001554; d = 32'h0;
        if (!op) begin
            if (i < 6) begin
                d = {8'h00, ec[i], 8'h00, ec[i]};
                a = (i == 1 || i == 4) ? 24'h000AA8 : (i == 5 ? ta : 24'h001554);
            end else begin
                d = 32'h00F000F0; a = 24'h001554;
            end
        end else begin
            if (i < 4) begin
                d = {8'h00, pc[i], 8'h00, pc[i]};
                a = (i == 1) ? 24'h000AA8 : (i == 3 ? ta : 24'h001554);
            end else if (i == 4) begin
                d = td; a = ta;
            end else begin
                d = 32'h00F000F0; a = ta;
            end
        end
    endfunction

    function automatic logic [1:0] exp_status(input logic op, input logic [31:0] m, input logic [31:0] d,
            input int m0, input int m1, input int c0, input int c1, input logic [31:0] corr, input int lim);
        int mx;
        mx = (c0 > c1) ? c0 : c1;
        if (op && ((m & d) != d)) return 2'd3;
        if (c0 >= HANG || c1 >= HANG) return 2'd2;
        if (mx >= 1 && lim <= 3*mx - 1) return 2'd2;
        if (m0 == 1 || m1 == 1) return 2'd1;
        if (op && corr != 0) return 2'd1;
        return 2'd0;
    endfunction

    task automatic run_op(input logic op, input logic [AW-1:0] ta, input logic [31:0] td,
                          input logic [31:0] m, input int m0, input int m1, input int c0, input int c1,
                          input logic [31:0] corr, input int lim, input bit busy_req, input string tag);
        logic [1:0] es;
        int nexp, cyc, wn_end;
        bit seq_ok, got;
        logic [AW-1:0] ea;
        logic [31:0] ed;
        for (int i = 0; i < 64; i++) fmem[i] = m;
        hmode[0] = m0; hmode[1] = m1; busy_cnt[0] = c0; busy_cnt[1] = c1;
        rr_seen[0] = 0; rr_seen[1] = 0; corrupt = corr; prog_seen = 0; wn = 0;
        tmo_limit = TW'(lim);
        es = exp_status(op, m, td, m0, m1, c0, c1, corr, lim);
        nexp = (es == 2'd3) ? 0 : (op ? 6 : 7);
        req_valid = 1; req_op = op; req_addr = ta; req_data = td;
        @(negedge clk);
        req_valid = 0;
        got = 0; cyc = 0;
        while (!got && cyc < 20000) begin
            if (busy_req && cyc == 3) begin req_valid = 1; req_op = ~op; req_addr = ta ^ 24'h40; end
            if (busy_req && cyc == 5) req_valid = 0;
            @(negedge clk);
            cyc++;
            if (done) got = 1;
        end
        check(got, {tag, " R10 done seen"}, 32'(got), 32'd1);
        check(status == es, {tag, " status R5 R6 R7 R8 R9"}, 32'(status), 32'(es));
        @(negedge clk);
        check(!done && req_ready, {tag, " R10 one-cycle done then idle"}, {30'h0, done, req_ready}, 32'h1);
        wn_end = wn;
        check(wn_end == nexp, {tag, " write count R3 R4 R5"}, 32'(wn_end), 32'(nexp));
        seq_ok = 1;
        for (int i = 0; i < nexp && i < 16; i++) begin
            exp_w(op, i, ta, td, ea, ed);
            if (wlog_a[i] != ea || wlog_d[i] != ed) seq_ok = 0;
        end
        check(seq_ok, {tag, " write sequence R2 R3 R4 R9"}, 32'(seq_ok), 32'd1);
        if (busy_req) begin
            repeat (6) @(negedge clk);
            check(wn == wn_end && !done, {tag, " R10 busy request ignored"}, 32'(wn), 32'(wn_end));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired R10 actual=%h expected=%h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        check(req_ready && !done && !bus_we && !bus_re, "R1 in reset", {28'h0, req_ready, done, bus_we, bus_re}, 32'h8);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && !done && !bus_we && !bus_re, "R1 idle after reset", {28'h0, req_ready, done, bus_we, bus_re}, 32'h8);

        // directed
        run_op(0, 24'h020000, 0, 32'h12345678, 0, 0, 2, 3, 0, 1000, 0, "erase ok R3");
        run_op(0, 24'h040000, 0, 32'h0, 0, 1, 1, 0, 0, 1000, 0, "erase hi fail R6");
        run_op(0, 24'h040000, 0, 32'h0, 1, 0, 0, 2, 0, 1000, 0, "erase lo fail R6");
        run_op(1, 24'h000104, 32'h12F45A80, 32'hFFFFFFFF, 0, 0, 1, 2, 0, 1000, 0, "prog ok R4");
        run_op(1, 24'h000108, 32'h0000FF00, 32'hFFFF00FF, 0, 0, 0, 0, 0, 1000, 0, "not erased R5");
        run_op(1, 24'h00010C, 32'h00800000, 32'hFFFFFFFF, 2, 0, 1, 0, 0, 1000, 0, "fault once ok R7");
        run_op(1, 24'h00010C, 32'h00000080, 32'hFFFFFFFF, 0, 2, 0, 3, 0, 1000, 0, "fault once hi R7");
        run_op(1, 24'h000110, 32'h55AA55AA, 32'hFFFFFFFF, 1, 0, 0, 0, 0, 1000, 0, "prog fail R7");
        run_op(1, 24'h000114, 32'h0F0F0F0F, 32'hFFFFFFFF, 0, 0, 0, 0, 32'h00000100, 1000, 0, "readback R9");
        run_op(0, 24'h060000, 0, 32'h0, 0, 0, HANG, HANG, 0, 20, 0, "erase hang R8");
        run_op(1, 24'h000118, 32'h00000001, 32'hFFFFFFFF, 0, 0, HANG, 0, 0, 20, 0, "prog hang R8");
        run_op(0, 24'h060000, 0, 32'h0, 1, 0, 0, HANG, 0, 20, 0, "fail plus hang R8");
        run_op(0, 24'h080000, 0, 32'h0, 0, 0, 2, 2, 0, 6, 0, "limit 6 ok R11");
        run_op(0, 24'h080000, 0, 32'h0, 0, 0, 2, 1, 0, 5, 0, "limit 5 tmo R11");
        run_op(1, 24'h00011C, 32'h00010001, 32'hFFFFFFFF, 0, 0, 0, 0, 0, 0, 0, "limit 0 ok R11");
        run_op(1, 24'h00011C, 32'h00010001, 32'hFFFFFFFF, 0, 0, 1, 0, 0, 0, 0, "limit 0 tmo R11");
        run_op(0, 24'h0A0000, 0, 32'h0, 0, 0, 3, 3, 0, 1000, 1, "busy req R10");

        // constrained random
        for (int k = 0; k < 60; k++) begin
            logic op;
            logic [31:0] m, d, corr;
            int m0, m1, c0, c1, lim;
            op = 1'($urandom_range(0, 1));
            m = $urandom();
            d = ($urandom_range(0, 3) == 0) ? $urandom() : (m & $urandom());
            m0 = op ? $urandom_range(0, 2) : $urandom_range(0, 1);
            m1 = op ? $urandom_range(0, 2) : $urandom_range(0, 1);
            c0 = $urandom_range(0, 4);
            c1 = $urandom_range(0, 4);
            lim = 1000;
            if ($urandom_range(0, 7) == 0) begin c0 = HANG; lim = 20; end
            corr = ($urandom_range(0, 7) == 0) ? 32'h00010000 : 32'h0;
            run_op(op, {14'h0, 6'($urandom_range(0, 63)), 4'h0}, d, m, m0, m1, c0, c1, corr, lim, 0, "random R6 R7");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule